// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Update

This block runs the four single-bit shift and rotate operations on one byte: shift left with zero fill, logical shift right with zero fill, and rotate left or right through the carry flag. The byte comes from one of two places. In register mode it is the accumulator, and the result goes back to the accumulator through a one-cycle write enable. In memory mode the block reads the byte over a simple byte memory port, computes the result and writes it back to the address it read from.

The status byte goes out with three bits updated: carry, zero and negative. All other bits are copied from the status presented at start. The flag positions are parameters. By default carry is bit 0, zero is bit 1 and negative is bit 7.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation code 2'b00 shifts left. Old bit 7 goes to carry and bit 0 becomes 0.
- R2: Operation code 2'b01 shifts right logically. Old bit 0 goes to carry and bit 7 becomes 0. A zero operand gives 0x00, sets zero and clears carry.
- R3: Operation code 2'b10 rotates left. Old bit 7 goes to carry and the incoming carry (status bit 0) goes to bit 0.
- R4: Operation code 2'b11 rotates right. Old bit 0 goes to carry and the incoming carry goes to bit 7.
- R5: Negative (status bit 7) equals bit 7 of the result. Zero (status bit 1) is 1 exactly when the result is 0x00.
- R6: Every status bit other than bits 0, 1 and 7 equals the same bit of `status_in`.
- R7: With `use_mem` high, `mem_rd` pulses in the cycle after start. The read data is taken one cycle later. `mem_wr` pulses in the next cycle with the result, to the same address, and `done` is high in that write cycle only. This is three cycles after start.
- R8: With `use_mem` low, the memory port stays idle. `done` and `acc_we` pulse together one cycle after start, and `result` holds the new accumulator value.
- R9: A start pulse that arrives while `busy` is high is ignored. It produces no extra `done` and does not change the running operation.
- R10: After reset, `done`, `busy`, `acc_we`, `mem_rd`, `mem_wr`, `result` and `status_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when idle |
| op | input | 2 | Operation select (see R1 to R4) |
| use_mem | input | 1 | 1 = memory byte, 0 = accumulator |
| addr | input | AW | Memory byte address |
| acc_in | input | 8 | Current accumulator value |
| status_in | input | 8 | Current status byte |
| mem_rd | output | 1 | Read strobe. Data is expected one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | AW | Memory address for the read and the write |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| result | output | 8 | Computed byte, held until the next operation |
| status_out | output | 8 | Updated status, held until the next operation |
| acc_we | output | 1 | Accumulator write enable pulse |
| done | output | 1 | Completion pulse |
| busy | output | 1 | High while an operation is running |

## Verification
The pass-through check on status bits compares `status_out` against the live `status_in` on the done cycle. It therefore assumes that the status input is held steady from start to done. The bench holds every input constant for the whole operation and changes inputs only between operations. The one exception is the start pulse sent during a busy window, and that pulse keeps the same status. The memory is modelled as a synchronous byte array with one cycle of read latency, which is the latency the write-back sequence is built around.

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int AW    = 16,
  parameter int C_BIT = 0,
  parameter int Z_BIT = 1,
  parameter int N_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          use_mem,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    acc_in,
  input  logic [7:0]    status_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    result,
  output logic [7:0]    status_out,
  output logic          acc_we,
  output logic          done,
  output logic          busy
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_ACC} state_t;
  state_t state;

  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    st_q;

  logic       in_cap;
  logic [1:0] op_s;
  logic [7:0] opnd, st_base, res_n, st_n;
  logic       cin, cout;

  assign in_cap  = (state == S_CAP);
  assign op_s    = in_cap ? op_q : op;
  assign opnd    = in_cap ? mem_rdata : acc_in;
  assign st_base = in_cap ? st_q : status_in;
  assign cin     = st_base[C_BIT];

  always_comb begin
    case (op_s)
      2'b00:   {cout, res_n} = {opnd, 1'b0};
      2'b01:   {res_n, cout} = {1'b0, opnd};
      2'b10:   {cout, res_n} = {opnd, cin};
      default: {res_n, cout} = {cin, opnd};
    endcase
    st_n        = st_base;
    st_n[C_BIT] = cout;
    st_n[Z_BIT] = (res_n == 8'h00);
    st_n[N_BIT] = res_n[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      st_q       <= '0;
      result     <= '0;
      status_out <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (use_mem) begin
            op_q   <= op;
            addr_q <= addr;
            st_q   <= status_in;
            state  <= S_RD;
          end else begin
            result     <= res_n;
            status_out <= st_n;
            state      <= S_ACC;
          end
        end
        S_RD:  state <= S_CAP;
        S_CAP: begin
          result     <= res_n;
          status_out <= st_n;
          state      <= S_WR;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = result;
  assign acc_we    = (state == S_ACC);
  assign done      = (state == S_WR) || (state == S_ACC);
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int AW    = 16,
  parameter int C_BIT = 0,
  parameter int Z_BIT = 1,
  parameter int N_BIT = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    status_in,
  input logic [7:0]    status_out,
  input logic [7:0]    result,
  input logic          acc_we,
  input logic          done
);
  logic [7:0] keep;
  always_comb begin
    keep = 8'hFF;
    keep[C_BIT] = 1'b0;
    keep[Z_BIT] = 1'b0;
    keep[N_BIT] = 1'b0;
  end

  AST_NEG_MATCH:   assert property (@(posedge clk) disable iff (!rst_n) done |-> status_out[N_BIT] == result[7]); // R5
  AST_ZERO_MATCH:  assert property (@(posedge clk) disable iff (!rst_n) done |-> status_out[Z_BIT] == (result == 8'h00)); // R5
  AST_KEEP_BITS:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (status_out & keep) == (status_in & keep)); // R6
  AST_RD_TO_WR:    assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> ##2 (mem_wr && done)); // R7
  AST_WR_SAME_ADR: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_wr) |-> mem_addr == $past(mem_addr, 2)); // R7
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_ACC_NO_MEM:  assert property (@(posedge clk) disable iff (!rst_n) acc_we |-> (!mem_wr && !mem_rd && done)); // R8
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.AW(AW), .C_BIT(C_BIT), .Z_BIT(Z_BIT), .N_BIT(N_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .status_in(status_in), .status_out(status_out), .result(result), .acc_we(acc_we), .done(done)
);

// File: tb/shift_rot_unit_test.sv
`timescale 1ns/1ps
module shift_rot_unit_test;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, start = 0, use_mem = 0;
  logic [1:0] op = 0;
  logic [AW-1:0] addr = 0;
  logic [7:0] acc_in = 0, status_in = 0, mem_rdata = 0;
  logic mem_rd, mem_wr, acc_we, done, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, result, status_out;

  shift_rot_unit #(.AW(AW)) uut (.*);

  always #5 clk = ~clk;

  logic [7:0] ram [256];
  int rd_cnt, wr_cnt, done_cnt;
  logic [AW-1:0] rd_adr, wr_adr;
  always @(posedge clk) begin
    if (mem_rd) begin mem_rdata <= ram[mem_addr[7:0]]; rd_cnt <= rd_cnt + 1; rd_adr <= mem_addr; end
    if (mem_wr) begin ram[mem_addr[7:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; wr_adr <= mem_addr; end
    if (done) done_cnt <= done_cnt + 1;
  end

  int checks = 0, errors = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {op, use_mem, 1'b0} nibble, operand, status_in, expected result, expected status
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    36'h0_81_00_02_01, 36'h4_01_00_00_03, 36'h8_40_01_81_80, 36'hC_01_01_80_81,
    36'hC_00_00_00_02, 36'h4_00_FF_00_7E, 36'h2_40_4C_80_CC, 36'h6_FE_83_7F_00,
    36'hA_80_00_00_03, 36'hE_02_01_81_80, 36'h8_FF_01_FF_81, 36'h0_00_40_00_42
  };

  int lat;
  logic [7:0] got_res, got_st;
  logic got_we;

  task automatic run_op(input logic [1:0] o, input logic m, input logic [7:0] d,
                        input logic [7:0] st, input logic [AW-1:0] a);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0;
    if (m) ram[a[7:0]] = d; else acc_in = d;
    op = o; use_mem = m; addr = a; status_in = st; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 10) begin @(negedge clk); lat++; end
    got_res = result; got_st = status_out; got_we = acc_we;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 done", done, 0);
    check("R10 busy", busy, 0);
    check("R10 rd/wr/we", {mem_rd, mem_wr, acc_we}, 0);
    check("R10 result", result, 0);
    check("R10 status", status_out, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      logic [AW-1:0] a;
      v = VEC[i];
      a = AW'(8'h20 + i);
      run_op(v[35:34], v[33], v[31:24], v[23:16], a);
      case (v[35:34])
        2'b00: check("R1 result", got_res, v[15:8]);
        2'b01: check("R2 result", got_res, v[15:8]);
        2'b10: check("R3 result", got_res, v[15:8]);
        default: check("R4 result", got_res, v[15:8]);
      endcase
      check("R5 R6 status", got_st, v[7:0]);
      if (v[33]) begin
        check("R7 latency", lat, 3);
        check("R7 one read one write", {rd_cnt[7:0], wr_cnt[7:0]}, 16'h0101);
        check("R7 read address", rd_adr, a);
        check("R7 write address", wr_adr, a);
        check("R7 memory written", ram[a[7:0]], v[15:8]);
        check("R7 acc_we idle", got_we, 0);
      end else begin
        check("R8 latency", lat, 1);
        check("R8 acc_we", got_we, 1);
        check("R8 no memory access", rd_cnt + wr_cnt, 0);
      end
    end

    // R9: start during busy window is ignored
    @(negedge clk);
    done_cnt = 0; rd_cnt = 0; wr_cnt = 0;
    ram[8'h55] = 8'h03;
    op = 2'b01; use_mem = 1; addr = 16'h0055; status_in = 8'h00; start = 1;
    @(negedge clk);
    op = 2'b00; use_mem = 0; acc_in = 8'hFF; addr = 16'h0077; start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    check("R9 single done", done_cnt, 1);
    check("R9 single write", wr_cnt, 1);
    check("R9 first op result", result, 8'h01);
    check("R9 first op status", status_out, 8'h01);
    check("R9 memory result", ram[8'h55], 8'h01);
    check("R9 busy cleared", busy, 0);

    // R2 corner: zero accumulator shifted right with carry set in
    run_op(2'b01, 1'b0, 8'h00, 8'h01, '0);
    check("R2 zero result", got_res, 8'h00);
    check("R2 zero flags", got_st, 8'h02);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule